// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the programming face of a multi-channel DMA controller. A 32-bit memory-mapped bus reaches a bank of per-channel register windows, each 0x100 bytes wide. In its window a channel holds its source and destination addresses, its address-mode and width controls, a burst size and burst count, a request-factor and gap control, a start request, and interrupt enables. The programmed values go straight to a transfer engine on flat per-channel output buses. The engine reports back per channel with busy, done and error indications.

Each channel keeps two raw event flags, end-of-transfer and error, which software clears by writing ones. It also shows a masked view of those flags filtered by the enables. The masked flags of every channel are ORed onto one shared interrupt line. A finished transfer drops the channel's start request by itself. The busy status stays high after a stop request until the engine says it has halted.

Top module: `xfer_chan_csr`

## Requirements
- R1: After reset every readable register reads 0, every engine output is 0 and `irq` is 0.
- R2: Address bits [ADDR_W-1:8] pick the channel. An address whose channel index is NUM_CH or more selects no channel: its writes change nothing and its reads return 0.
- R3: The configuration registers read back what was written, limited to their fields, and drive the matching engine outputs. Offset 0x08 keeps the gap count in bits 23:16 and the request factor in bits 5:0. Offsets 0x10 and 0x14 keep the width code in bits 25:24 and the fixed-address flag in bit 4. Offsets 0x18 and 0x1C keep the upper address (EXT_W bits), 0x20 and 0x24 keep the low 32 address bits, 0x28 keeps the burst size in bits 25:0 and 0x2C keeps the burst count in bits 15:0.
- R4: Writes to any other offset, unaligned offsets included, are ignored, and reads of them return 0.
- R5: Bit 0 of offset 0x30 is the start request and drives `eng_req`. Writing 0 there withdraws it.
- R6: Bit 0 of offset 0x40 reads 1 while the start request is set or `eng_busy` is high. After a stop it stays 1 until `eng_busy` falls.
- R7: A one-cycle `eng_done` pulse clears the start request and sets the end flag (bit 0 of offset 0x44) one cycle later. A start write in the same cycle takes priority over the clear.
- R8: A one-cycle `eng_err` pulse sets the error flag (bit 1 of offset 0x44) and leaves the start request as it was.
- R9: Writing to offset 0x44 clears each flag whose data bit is 1 and leaves the others. An event arriving in the same cycle as the clear wins.
- R10: Offset 0x34 holds the enables (bit 0 end, bit 1 error). Offset 0x48 reads the raw flags ANDed with the enables in the same bit positions, and writes to it are ignored.
- R11: `irq` is high exactly when some masked flag of some channel is set.
- R12: `bus_rdata` presents the value addressed by a `bus_rd` cycle on the following cycle and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address: channel index above bit 8, register offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_req | output | NUM_CH | Start request per channel |
| eng_src_addr | output | NUM_CH*(32+EXT_W) | Source address per channel |
| eng_dst_addr | output | NUM_CH*(32+EXT_W) | Destination address per channel |
| eng_src_mode | output | NUM_CH*3 | {fixed flag, width code} for the source |
| eng_dst_mode | output | NUM_CH*3 | {fixed flag, width code} for the destination |
| eng_burst_size | output | NUM_CH*26 | Burst size per channel |
| eng_burst_cnt | output | NUM_CH*16 | Burst count per channel |
| eng_req_sel | output | NUM_CH*6 | Request factor per channel |
| eng_gap | output | NUM_CH*8 | Gap count between bursts per channel |
| eng_busy | input | NUM_CH | Engine transferring |
| eng_done | input | NUM_CH | Transfer finished (one-cycle pulse) |
| eng_err | input | NUM_CH | Transfer error (one-cycle pulse) |
| irq | output | 1 | Shared interrupt |

## Verification
The bench builds the block with NUM_CH = 3 and EXT_W = 8. At that setting the two-bit channel field has an index, 3, that maps to no channel, so the decode of an empty window can be tested at the ports. The eight-bit upper address shows that the field is truncated on read-back. With three channels, an event on one channel can be checked against the flags of another, and the shared line can be checked while flags in several channels are set and cleared. Same-cycle collisions are driven on purpose: an event against a clear, and a completion against a start write.

// File: rtl/xfer_csr_pkg.sv
package xfer_csr_pkg;

  localparam int WIN_BITS = 8;
  localparam int BSIZE_W  = 26;
  localparam int BCNT_W   = 16;
  localparam int RFAC_W   = 6;
  localparam int GAP_W    = 8;
  localparam int MODE_W   = 3;

  localparam logic [7:0] OFF_REQCTL = 8'h08;
  localparam logic [7:0] OFF_SMODE  = 8'h10;
  localparam logic [7:0] OFF_DMODE  = 8'h14;
  localparam logic [7:0] OFF_SHI    = 8'h18;
  localparam logic [7:0] OFF_DHI    = 8'h1C;
  localparam logic [7:0] OFF_SLO    = 8'h20;
  localparam logic [7:0] OFF_DLO    = 8'h24;
  localparam logic [7:0] OFF_BSIZE  = 8'h28;
  localparam logic [7:0] OFF_BCNT   = 8'h2C;
  localparam logic [7:0] OFF_GO     = 8'h30;
  localparam logic [7:0] OFF_IEN    = 8'h34;
  localparam logic [7:0] OFF_STAT   = 8'h40;
  localparam logic [7:0] OFF_RAW    = 8'h44;
  localparam logic [7:0] OFF_MASKED = 8'h48;

  typedef struct packed {
    logic       fixed;
    logic [1:0] width;
  } addr_mode_t;

  typedef struct packed {
    logic [GAP_W-1:0]  gap;
    logic [RFAC_W-1:0] fac;
  } reqctl_t;

endpackage

// File: rtl/xfer_csr_decode.sv
module xfer_csr_decode #(
  parameter int NUM_CH   = 4,
  parameter int CH_SEL_W = 2,
  parameter int ADDR_W   = 10
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CH-1:0] ch_sel,
  output logic [7:0]        reg_off
);
  import xfer_csr_pkg::*;

  logic [CH_SEL_W-1:0] ch_idx;

  assign ch_idx  = bus_addr[ADDR_W-1:WIN_BITS];
  assign reg_off = bus_addr[WIN_BITS-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel[g] = (ch_idx == CH_SEL_W'(g));
  end

endmodule

// File: rtl/xfer_csr_chan.sv
module xfer_csr_chan #(
  parameter int EXT_W = 8,
  localparam int AW   = 32 + EXT_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel,
  input  logic                          wr,
  input  logic [7:0]                    off,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rd_val,
  input  logic                          eng_busy,
  input  logic                          eng_done,
  input  logic                          eng_err,
  output logic                          go,
  output logic [AW-1:0]                 src_addr,
  output logic [AW-1:0]                 dst_addr,
  output logic [xfer_csr_pkg::MODE_W-1:0]  src_mode,
  output logic [xfer_csr_pkg::MODE_W-1:0]  dst_mode,
  output logic [xfer_csr_pkg::BSIZE_W-1:0] burst_size,
  output logic [xfer_csr_pkg::BCNT_W-1:0]  burst_cnt,
  output logic [xfer_csr_pkg::RFAC_W-1:0]  req_fac,
  output logic [xfer_csr_pkg::GAP_W-1:0]   gap,
  output logic [1:0]                    masked
);
  import xfer_csr_pkg::*;

  reqctl_t          reqctl_q;
  addr_mode_t       smode_q, dmode_q;
  logic [EXT_W-1:0] shi_q, dhi_q;
  logic [31:0]      slo_q, dlo_q;
  logic [BSIZE_W-1:0] bsz_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic             go_q, go_d;
  logic [1:0]       ien_q;
  logic [1:0]       raw_q, raw_d;

  logic wsel;
  logic we_reqctl, we_smode, we_dmode, we_shi, we_dhi, we_slo, we_dlo;
  logic we_bsz, we_bcnt, we_go, we_ien, we_raw;
  logic en_go, en_raw;

  // next-state and enables
  always_comb begin
    wsel      = sel && wr;
    we_reqctl = wsel && (off == OFF_REQCTL);
    we_smode  = wsel && (off == OFF_SMODE);
    we_dmode  = wsel && (off == OFF_DMODE);
    we_shi    = wsel && (off == OFF_SHI);
    we_dhi    = wsel && (off == OFF_DHI);
    we_slo    = wsel && (off == OFF_SLO);
    we_dlo    = wsel && (off == OFF_DLO);
    we_bsz    = wsel && (off == OFF_BSIZE);
    we_bcnt   = wsel && (off == OFF_BCNT);
    we_go     = wsel && (off == OFF_GO);
    we_ien    = wsel && (off == OFF_IEN);
    we_raw    = wsel && (off == OFF_RAW);

    go_d = go_q;
    if (eng_done) go_d = 1'b0;
    if (we_go)    go_d = wdata[0];
    en_go = we_go || eng_done;

    raw_d = raw_q;
    if (we_raw) raw_d = raw_q & ~wdata[1:0];
    raw_d  = raw_d | {eng_err, eng_done};
    en_raw = we_raw || eng_done || eng_err;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqctl_q <= '0;
      smode_q  <= '0;
      dmode_q  <= '0;
      shi_q    <= '0;
      dhi_q    <= '0;
      slo_q    <= '0;
      dlo_q    <= '0;
      bsz_q    <= '0;
      bcnt_q   <= '0;
      go_q     <= 1'b0;
      ien_q    <= '0;
      raw_q    <= '0;
    end else begin
      if (we_reqctl) reqctl_q <= '{gap: wdata[23:16], fac: wdata[5:0]};
      if (we_smode)  smode_q  <= '{fixed: wdata[4], width: wdata[25:24]};
      if (we_dmode)  dmode_q  <= '{fixed: wdata[4], width: wdata[25:24]};
      if (we_shi)    shi_q    <= wdata[EXT_W-1:0];
      if (we_dhi)    dhi_q    <= wdata[EXT_W-1:0];
      if (we_slo)    slo_q    <= wdata;
      if (we_dlo)    dlo_q    <= wdata;
      if (we_bsz)    bsz_q    <= wdata[BSIZE_W-1:0];
      if (we_bcnt)   bcnt_q   <= wdata[BCNT_W-1:0];
      if (en_go)     go_q     <= go_d;
      if (we_ien)    ien_q    <= wdata[1:0];
      if (en_raw)    raw_q    <= raw_d;
    end
  end

  // read-back view
  always_comb begin
    rd_val = '0;
    unique case (off)
      OFF_REQCTL: rd_val = {8'h00, reqctl_q.gap, 10'h000, reqctl_q.fac};
      OFF_SMODE:  rd_val = {6'h00, smode_q.width, 19'h0, smode_q.fixed, 4'h0};
      OFF_DMODE:  rd_val = {6'h00, dmode_q.width, 19'h0, dmode_q.fixed, 4'h0};
      OFF_SHI:    rd_val = 32'(shi_q);
      OFF_DHI:    rd_val = 32'(dhi_q);
      OFF_SLO:    rd_val = slo_q;
      OFF_DLO:    rd_val = dlo_q;
      OFF_BSIZE:  rd_val = 32'(bsz_q);
      OFF_BCNT:   rd_val = 32'(bcnt_q);
      OFF_GO:     rd_val = {31'h0, go_q};
      OFF_IEN:    rd_val = {30'h0, ien_q};
      OFF_STAT:   rd_val = {31'h0, go_q | eng_busy};
      OFF_RAW:    rd_val = {30'h0, raw_q};
      OFF_MASKED: rd_val = {30'h0, raw_q & ien_q};
      default:    rd_val = '0;
    endcase
  end

  assign go         = go_q;
  assign src_addr   = {shi_q, slo_q};
  assign dst_addr   = {dhi_q, dlo_q};
  assign src_mode   = smode_q;
  assign dst_mode   = dmode_q;
  assign burst_size = bsz_q;
  assign burst_cnt  = bcnt_q;
  assign req_fac    = reqctl_q.fac;
  assign gap        = reqctl_q.gap;
  assign masked     = raw_q & ien_q;

  AST_DONE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !we_go) |=> !go_q); // R7
  AST_DONE_RAISES_END: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> raw_q[0]); // R7
  AST_ERR_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> raw_q[1]); // R8
  AST_ERR_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_err && !eng_done && !we_go) |=> (go_q == $past(go_q))); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_raw && wdata[0] && !eng_done) |=> !raw_q[0]); // R9

endmodule

// File: rtl/xfer_csr_irq.sv
module xfer_csr_irq #(
  parameter int NUM_CH = 4
) (
  input  logic [2*NUM_CH-1:0] flags,
  output logic                irq
);
  assign irq = |flags;
endmodule

// File: rtl/xfer_chan_csr.sv
module xfer_chan_csr #(
  parameter int  NUM_CH   = 4,
  parameter int  EXT_W    = 8,
  localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W   = CH_SEL_W + 8,
  localparam int AW       = 32 + EXT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_CH-1:0]     eng_req,
  output logic [NUM_CH*AW-1:0]  eng_src_addr,
  output logic [NUM_CH*AW-1:0]  eng_dst_addr,
  output logic [NUM_CH*3-1:0]   eng_src_mode,
  output logic [NUM_CH*3-1:0]   eng_dst_mode,
  output logic [NUM_CH*26-1:0]  eng_burst_size,
  output logic [NUM_CH*16-1:0]  eng_burst_cnt,
  output logic [NUM_CH*6-1:0]   eng_req_sel,
  output logic [NUM_CH*8-1:0]   eng_gap,
  input  logic [NUM_CH-1:0]     eng_busy,
  input  logic [NUM_CH-1:0]     eng_done,
  input  logic [NUM_CH-1:0]     eng_err,
  output logic                  irq
);

  logic [NUM_CH-1:0]   ch_sel;
  logic [7:0]          reg_off;
  logic [31:0]         rd_val [NUM_CH];
  logic [2*NUM_CH-1:0] masked_all;
  logic [31:0]         rd_mux;

  xfer_csr_decode #(
    .NUM_CH  (NUM_CH),
    .CH_SEL_W(CH_SEL_W),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .bus_addr(bus_addr),
    .ch_sel  (ch_sel),
    .reg_off (reg_off)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    xfer_csr_chan #(.EXT_W(EXT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (ch_sel[g]),
      .wr        (bus_wr),
      .off       (reg_off),
      .wdata     (bus_wdata),
      .rd_val    (rd_val[g]),
      .eng_busy  (eng_busy[g]),
      .eng_done  (eng_done[g]),
      .eng_err   (eng_err[g]),
      .go        (eng_req[g]),
      .src_addr  (eng_src_addr[g*AW +: AW]),
      .dst_addr  (eng_dst_addr[g*AW +: AW]),
      .src_mode  (eng_src_mode[g*3 +: 3]),
      .dst_mode  (eng_dst_mode[g*3 +: 3]),
      .burst_size(eng_burst_size[g*26 +: 26]),
      .burst_cnt (eng_burst_cnt[g*16 +: 16]),
      .req_fac   (eng_req_sel[g*6 +: 6]),
      .gap       (eng_gap[g*8 +: 8]),
      .masked    (masked_all[g*2 +: 2])
    );
  end

  xfer_csr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .flags(masked_all),
    .irq  (irq)
  );

  // read select
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) rd_mux = rd_mux | rd_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel)); // R2
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R12

endmodule

// File: tb/xfer_chan_csr_bench.sv
module xfer_chan_csr_bench;

  localparam int NCH = 3;
  localparam int EW  = 8;
  localparam int AWB = 10;
  localparam int AW  = 32 + EW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [AWB-1:0]  bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  eng_req;
  logic [NCH*AW-1:0] eng_src_addr, eng_dst_addr;
  logic [NCH*3-1:0]  eng_src_mode, eng_dst_mode;
  logic [NCH*26-1:0] eng_burst_size;
  logic [NCH*16-1:0] eng_burst_cnt;
  logic [NCH*6-1:0]  eng_req_sel;
  logic [NCH*8-1:0]  eng_gap;
  logic [NCH-1:0]  eng_busy = '0;
  logic [NCH-1:0]  eng_done = '0;
  logic [NCH-1:0]  eng_err = '0;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        pend = 1'b0;

  always #10 clk = ~clk;

  xfer_chan_csr #(.NUM_CH(NCH), .EXT_W(EW)) u_xfer_chan_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_req(eng_req), .eng_src_addr(eng_src_addr), .eng_dst_addr(eng_dst_addr),
    .eng_src_mode(eng_src_mode), .eng_dst_mode(eng_dst_mode),
    .eng_burst_size(eng_burst_size), .eng_burst_cnt(eng_burst_cnt),
    .eng_req_sel(eng_req_sel), .eng_gap(eng_gap),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        chk(64'(bus_rdata), 64'hBAD, "R12 unexpected read");
      end else begin
        chk(64'(bus_rdata), 64'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AWB'(ch * 256 + int'(off)); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [7:0] off, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AWB'(ch * 256 + int'(off));
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done(input int ch);
    @(negedge clk); eng_done[ch] = 1'b1;
    @(negedge clk); eng_done[ch] = 1'b0;
  endtask

  task automatic pulse_err(input int ch);
    @(negedge clk); eng_err[ch] = 1'b1;
    @(negedge clk); eng_err[ch] = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(64'(irq), 0, "R1 irq");
    chk(64'(eng_req), 0, "R1 eng_req");
    chk(64'(eng_burst_size), 0, "R1 burst size out");
    rd(0, 8'h20, 32'h0, "R1 src lo");
    rd(2, 8'h40, 32'h0, "R1 status");
    rd(1, 8'h44, 32'h0, "R1 raw");

    // R3 read-back and field limits
    wr(1, 8'h20, 32'hDEADBEEF);
    rd(1, 8'h20, 32'hDEADBEEF, "R3 src lo");
    chk(64'(eng_src_addr[1*AW +: 32]), 64'hDEADBEEF, "R3 src lo out");
    rd(0, 8'h20, 32'h0, "R2 other channel untouched");
    wr(1, 8'h28, 32'hFFFFFFFF);
    rd(1, 8'h28, 32'h03FFFFFF, "R3 burst size");
    wr(1, 8'h2C, 32'hFFFFFFFF);
    rd(1, 8'h2C, 32'h0000FFFF, "R3 burst count");
    wr(1, 8'h08, 32'hFFFFFFFF);
    rd(1, 8'h08, 32'h00FF003F, "R3 request control");
    chk(64'(eng_gap[8 +: 8]), 64'hFF, "R3 gap out");
    wr(1, 8'h10, 32'hFFFFFFFF);
    rd(1, 8'h10, 32'h03000010, "R3 src mode");
    chk(64'(eng_src_mode[3 +: 3]), 64'h7, "R3 src mode out");
    wr(1, 8'h14, 32'h02000000);
    rd(1, 8'h14, 32'h02000000, "R3 dst mode");
    wr(1, 8'h1C, 32'hFFFFFF5A);
    rd(1, 8'h1C, 32'h0000005A, "R3 dst hi");
    chk(64'(eng_dst_addr[1*AW+32 +: 8]), 64'h5A, "R3 dst hi out");

    // R4 unused offsets
    wr(1, 8'h0C, 32'hFFFFFFFF);
    rd(1, 8'h0C, 32'h0, "R4 unused 0x0C");
    wr(1, 8'h22, 32'h12345678);
    rd(1, 8'h22, 32'h0, "R4 unaligned");
    rd(1, 8'h20, 32'hDEADBEEF, "R4 unaligned write left src lo");

    // R2 window with no channel
    wr(3, 8'h20, 32'hCAFEF00D);
    rd(3, 8'h20, 32'h0, "R2 empty window read");
    rd(0, 8'h20, 32'h0, "R2 empty window write ch0");
    rd(1, 8'h20, 32'hDEADBEEF, "R2 empty window write ch1");

    // R5 / R6 start, stop, lingering busy
    wr(0, 8'h30, 32'h1);
    chk(64'(eng_req), 64'h1, "R5 start");
    rd(0, 8'h30, 32'h1, "R5 start readback");
    rd(0, 8'h40, 32'h1, "R6 status while requested");
    @(negedge clk); eng_busy[0] = 1'b1;
    wr(0, 8'h30, 32'h0);
    chk(64'(eng_req), 64'h0, "R5 stop");
    rd(0, 8'h40, 32'h1, "R6 busy lingers");
    @(negedge clk); eng_busy[0] = 1'b0;
    rd(0, 8'h40, 32'h0, "R6 status idle");

    // R7 R8 R10 R11 events on channel 2
    wr(2, 8'h34, 32'h1);
    wr(2, 8'h30, 32'h1);
    chk(64'(eng_req), 64'h4, "R5 ch2 start");
    pulse_done(2);
    chk(64'(eng_req), 64'h0, "R7 done drops request");
    chk(64'(irq), 1, "R11 irq on end");
    rd(2, 8'h44, 32'h1, "R7 end flag");
    rd(2, 8'h48, 32'h1, "R10 masked end");
    pulse_err(2);
    rd(2, 8'h44, 32'h3, "R8 error flag");
    rd(2, 8'h48, 32'h1, "R10 error masked off");
    wr(2, 8'h48, 32'h3);
    rd(2, 8'h48, 32'h1, "R10 masked write ignored");
    wr(2, 8'h44, 32'h1);
    rd(2, 8'h44, 32'h2, "R9 clear end only");
    chk(64'(irq), 0, "R11 irq drops");
    wr(2, 8'h44, 32'h2);
    rd(2, 8'h44, 32'h0, "R9 clear error");

    // R9 event against clear in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AWB'(2 * 256 + 'h44); bus_wdata = 32'h1;
    eng_done[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_done[2] = 1'b0;
    rd(2, 8'h44, 32'h1, "R9 set beats clear");
    chk(64'(irq), 1, "R11 irq after collision");
    wr(2, 8'h44, 32'h3);

    // R7 start write against done in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AWB'(2 * 256 + 'h30); bus_wdata = 32'h1;
    eng_done[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_done[2] = 1'b0;
    chk(64'(eng_req), 64'h4, "R7 start write wins");
    rd(2, 8'h44, 32'h1, "R7 end flag on collision");
    wr(2, 8'h30, 32'h0);
    wr(2, 8'h44, 32'h1);
    chk(64'(irq), 0, "R11 irq clear");

    // R8 R11 error on channel 1 with request held
    wr(1, 8'h34, 32'h2);
    wr(1, 8'h30, 32'h1);
    pulse_err(1);
    chk(64'(eng_req), 64'h2, "R8 request kept on error");
    chk(64'(irq), 1, "R11 irq from ch1 error");
    rd(1, 8'h48, 32'h2, "R10 masked error");
    rd(2, 8'h44, 32'h0, "R11 other channel flags clear");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule